// File: doc/BRIEF.md
# Serial Flash Auto-Increment Program Responder

This block is the device side of a serial-peripheral-bus link that behaves like a serial flash during sequential byte programming. It oversamples the bus clock, chip select and data-in lines with the system clock, frames bytes, and decodes four opcodes: set write enable (0x06), clear write enable (0x04), read status (0x05) and auto-increment program (0xAF). Programmed bytes are merged into a small on-chip byte array. Each write is shown on a write-strobe output together with its address and the merged value.

The first program frame after write enable carries a 24-bit start address and one data byte. After that, the responder stays in a sticky sequential mode. In this mode each further program frame carries only a data byte, which lands at the next address. The mode ends on clear-write-enable, or after the byte at the highest unprotected address `UNPROT_TOP` is written. Either exit also drops the write-enable latch. A busy flag is held for `PROG_CYCLES` system clocks after every byte. The bus is used in mode 0. Each SCK high and low phase must last at least six system clocks.

The sequencer has six states. S_OPC waits for the opcode. S_ADDR collects the three address bytes. S_DATA waits for the data byte. S_HOLD waits for chip select to rise so the write can start. S_STAT shifts out status. S_DROP discards the rest of a frame. The transitions are as follows:
- S_OPC goes to S_STAT on 0x05.
- S_OPC goes to S_ADDR on an accepted 0xAF outside the mode.
- S_OPC goes to S_DATA on an accepted 0xAF inside the mode.
- S_OPC goes to S_DROP on anything else.
- S_ADDR goes to S_DATA after a legal third address byte, or to S_DROP after a protected one.
- S_DATA goes to S_HOLD on the data byte.
- Any state returns to S_OPC when chip select rises; a rise in S_HOLD also launches the write.

Top module: `aai_flash_resp`

## Requirements
- R1: After reset, busy is low, no write strobe has fired, and the status byte reads 0x00.
- R2: Opcode 0x06 sets the write-enable latch, seen as status bit 1. An 0xAF frame received while the latch is clear produces no write and changes no state.
- R3: The first 0xAF frame takes a 24-bit address MSB first, then one data byte. When chip select rises, wr_stb pulses once with that address.
- R4: While sequential mode is active, an 0xAF frame carries one data byte, which is written at the address after the previous write.
- R5: busy rises together with each wr_stb and stays high for PROG_CYCLES clocks. While busy, every opcode except 0x05 is ignored.
- R6: Opcode 0x04 clears the write-enable latch and ends sequential mode, so the next 0xAF frame expects an address again.
- R7: Opcode 0x05 makes the responder shift out a status byte MSB first on miso, one byte per following byte slot. In that byte, bit 0 is busy, bit 1 is the write-enable latch, and the other bits are 0.
- R8: Writing address UNPROT_TOP ends sequential mode and clears the latch. No write ever goes to an address above UNPROT_TOP.
- R9: A start address above UNPROT_TOP makes the program frame a no-op, and the latch stays set.
- R10: The stored byte becomes the old stored value AND the incoming byte, and wr_data shows that merged value. The array resets to 0xFF.
- R11: In sequential mode, a frame whose opcode is not 0xAF, 0x04 or 0x05 has no effect, and 0x06 is among these.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Bus clock, mode 0 |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data into the responder |
| miso | output | 1 | Serial status out |
| wr_stb | output | 1 | One-cycle pulse per programmed byte |
| wr_addr | output | 24 | Address of the programmed byte |
| wr_data | output | 8 | Merged value stored at wr_addr |
| busy | output | 1 | Byte program in progress |

## Verification
Program frames are sent in five situations: with the latch clear, as a first frame at a legal address, as a data-only frame in mode, as a data-only frame while busy, and as a first frame at a protected address. Comparing the strobe count and address across these cases separates the acceptance rules from the address-pointer rules. Stray opcodes and 0x06 inside the mode, followed by a further program frame, show that the mode and the pointer survive such frames. A run ending at the top unprotected address, followed by a re-programme of an earlier address with fewer one bits, shows that there is no wrap and that the array merge is an AND.

// File: rtl/aaif_pkg.sv
package aaif_pkg;
    localparam logic [7:0] OP_SET_WE  = 8'h06;
    localparam logic [7:0] OP_CLR_WE  = 8'h04;
    localparam logic [7:0] OP_STATUS  = 8'h05;
    localparam logic [7:0] OP_SEQPROG = 8'hAF;
    localparam int         ADDR_W     = 24;

    typedef enum logic [2:0] {
        S_OPC,
        S_ADDR,
        S_DATA,
        S_HOLD,
        S_STAT,
        S_DROP
    } seq_state_e;
endpackage

// File: rtl/spi_link.sv
module spi_link #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    input  logic [7:0] tx_byte,
    output logic       tx_bit,
    output logic [7:0] rx_byte,
    output logic       byte_done,
    output logic       frame_end
);
    localparam int QW = SYNC_STAGES + 1;

    logic [QW-1:0]          sck_q;
    logic [QW-1:0]          cs_q;
    logic [SYNC_STAGES-1:0] mosi_q;
    logic [2:0]             bit_cnt;
    logic [6:0]             sh;
    logic [7:0]             tx;
    logic                   sck_rise, sck_fall, cs_act, din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q  <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sck_q  <= {sck_q[QW-2:0], sck};
            cs_q   <= {cs_q[QW-2:0], cs_n};
            mosi_q <= {mosi_q[SYNC_STAGES-2:0], mosi};
        end
    end

    assign sck_rise  = sck_q[QW-2] & ~sck_q[QW-1];
    assign sck_fall  = ~sck_q[QW-2] & sck_q[QW-1];
    assign cs_act    = ~cs_q[QW-2];
    assign frame_end = cs_q[QW-2] & ~cs_q[QW-1];
    assign din       = mosi_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt   <= '0;
            sh        <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            tx        <= '0;
        end else begin
            byte_done <= cs_act && sck_rise && (bit_cnt == 3'd7);
            if (!cs_act) begin
                bit_cnt <= '0;
                tx      <= '0;
            end else begin
                if (sck_rise) begin
                    sh      <= {sh[5:0], din};
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) rx_byte <= {sh, din};
                end
                if (sck_fall) begin
                    if (bit_cnt == 3'd0) tx <= tx_byte;
                    else                 tx <= {tx[6:0], 1'b0};
                end
            end
        end
    end

    assign tx_bit = tx[7];
endmodule

// File: rtl/busy_timer.sv
module busy_timer #(
    parameter int CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CW'(CYC);
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/byte_store.sv
module byte_store #(
    parameter int AW = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go,
    input  logic [aaif_pkg::ADDR_W-1:0] go_addr,
    input  logic [7:0]                 go_data,
    output logic                       wr_stb,
    output logic [aaif_pkg::ADDR_W-1:0] wr_addr,
    output logic [7:0]                 wr_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];
    logic [7:0] merged;

    assign merged = mem[go_addr[AW-1:0]] & go_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= go;
            if (go) begin
                mem[go_addr[AW-1:0]] <= merged;
                wr_addr              <= go_addr;
                wr_data              <= merged;
            end
        end
    end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
    import aaif_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TOP_ADDR = 24'h0000FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_done,
    input  logic [7:0]        rx_byte,
    input  logic              frame_end,
    input  logic              busy,
    output logic              go,
    output logic [ADDR_W-1:0] go_addr,
    output logic [7:0]        go_data,
    output logic              wel,
    output logic              aai,
    output logic              in_status,
    output logic [7:0]        status_byte
);
    seq_state_e        state, nxt;
    logic [15:0]       abuf;
    logic [1:0]        acnt;
    logic [ADDR_W-1:0] ptr;
    logic [ADDR_W-1:0] addr_full;
    logic [7:0]        dbuf;
    logic              opc_ok;

    assign addr_full = {abuf, rx_byte};
    assign opc_ok    = byte_done && (state == S_OPC) && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OPC;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (frame_end) begin
            nxt = S_OPC;
        end else if (byte_done) begin
            unique case (state)
                S_OPC: begin
                    if (rx_byte == OP_STATUS)
                        nxt = S_STAT;
                    else if (!busy && wel && rx_byte == OP_SEQPROG)
                        nxt = aai ? S_DATA : S_ADDR;
                    else
                        nxt = S_DROP;
                end
                S_ADDR: begin
                    if (acnt == 2'd2)
                        nxt = (addr_full > TOP_ADDR) ? S_DROP : S_DATA;
                end
                S_DATA:  nxt = S_HOLD;
                S_HOLD:  nxt = S_HOLD;
                S_STAT:  nxt = S_STAT;
                default: nxt = S_DROP;
            endcase
        end
    end

    always_comb begin
        go          = frame_end && (state == S_HOLD);
        in_status   = (state == S_STAT);
        status_byte = {6'b0, wel, busy};
        go_addr     = ptr;
        go_data     = dbuf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            aai  <= 1'b0;
            abuf <= '0;
            acnt <= '0;
            ptr  <= '0;
            dbuf <= 8'hFF;
        end else begin
            if (state == S_OPC) acnt <= '0;
            if (opc_ok) begin
                if (rx_byte == OP_SET_WE && !aai) wel <= 1'b1;
                if (rx_byte == OP_CLR_WE) begin
                    wel <= 1'b0;
                    aai <= 1'b0;
                end
            end
            if (byte_done && state == S_ADDR) begin
                abuf <= {abuf[7:0], rx_byte};
                acnt <= acnt + 2'd1;
                if (acnt == 2'd2 && addr_full <= TOP_ADDR) ptr <= addr_full;
            end
            if (byte_done && state == S_DATA) dbuf <= rx_byte;
            if (go) begin
                ptr <= ptr + ADDR_W'(1);
                if (ptr == TOP_ADDR) begin
                    aai <= 1'b0;
                    wel <= 1'b0;
                end else begin
                    aai <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/aai_flash_resp.sv
module aai_flash_resp #(
    parameter int          MEM_AW      = 8,
    parameter int          PROG_CYCLES = 64,
    parameter logic [23:0] UNPROT_TOP  = 24'h0000FF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck,
    input  logic        cs_n,
    input  logic        mosi,
    output logic        miso,
    output logic        wr_stb,
    output logic [23:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        busy
);
    logic       tx_bit, byte_done, frame_end, go, in_status;
    logic [7:0] rx_byte, status_byte, go_data;
    logic [23:0] go_addr;
    logic       wel_q, aai_q;

    spi_link u_link (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .tx_byte(status_byte), .tx_bit(tx_bit), .rx_byte(rx_byte),
        .byte_done(byte_done), .frame_end(frame_end)
    );

    cmd_seq #(.TOP_ADDR(UNPROT_TOP)) u_seq (
        .clk(clk), .rst_n(rst_n), .byte_done(byte_done), .rx_byte(rx_byte),
        .frame_end(frame_end), .busy(busy), .go(go), .go_addr(go_addr),
        .go_data(go_data), .wel(wel_q), .aai(aai_q), .in_status(in_status),
        .status_byte(status_byte)
    );

    busy_timer #(.CYC(PROG_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(go), .busy(busy)
    );

    byte_store #(.AW(MEM_AW)) u_store (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_data(go_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign miso = in_status & tx_bit;
endmodule

// File: rtl/aai_flash_resp_chk.sv
module aai_flash_resp_chk #(
    parameter logic [23:0] TOP_ADDR = 24'h0000FF
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_stb,
    input logic [23:0] wr_addr,
    input logic        busy,
    input logic        wel,
    input logic        aai
);
    // R5
    busy_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy);

    // R5
    no_strobe_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !$past(busy));

    // R2
    strobe_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(wel));

    // R8
    top_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr == TOP_ADDR) |-> (!wel && !aai));

    // R9
    no_protected_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> (wr_addr <= TOP_ADDR));

    // R6
    mode_implies_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aai |-> wel);
endmodule

bind aai_flash_resp aai_flash_resp_chk #(.TOP_ADDR(UNPROT_TOP)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .busy(busy), .wel(wel_q), .aai(aai_q)
);

// File: tb/sim_aai_flash_resp.sv
`timescale 1ns/1ps
module sim_aai_flash_resp;
    localparam int HALF = 6;
    localparam int PROG = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso, wr_stb, busy;
    logic [23:0] wr_addr;
    logic [7:0]  wr_data;

    int          n_run = 0;
    int          n_fail = 0;
    int          strobes = 0;
    logic [23:0] last_a = '0;
    logic [7:0]  last_d = '0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    aai_flash_resp #(.PROG_CYCLES(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .busy(busy)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            strobes++;
            last_a = wr_addr;
            last_d = wr_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [7:0] o, output logic [7:0] i);
        for (int b = 7; b >= 0; b--) begin
            mosi = o[b];
            ticks(HALF);
            sck = 1'b1;
            i[b] = miso;
            ticks(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic open_f();
        cs_n = 1'b0;
        ticks(HALF);
    endtask

    task automatic close_f();
        ticks(HALF);
        cs_n = 1'b1;
        ticks(2 * HALF);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        open_f(); xfer(op, d); close_f();
    endtask

    task automatic prog_first(input logic [23:0] a, input logic [7:0] v);
        logic [7:0] d;
        open_f();
        xfer(8'hAF, d); xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
        xfer(v, d);
        close_f();
    endtask

    task automatic prog_next(input logic [7:0] v);
        logic [7:0] d;
        open_f(); xfer(8'hAF, d); xfer(v, d); close_f();
    endtask

    task automatic rd_status(output logic [7:0] s);
        logic [7:0] d;
        open_f(); xfer(8'h05, d); xfer(8'h00, s); close_f();
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int k = 0; k < 50; k++) begin
            rd_status(s);
            if (s[0] == 1'b0) break;
        end
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R1 busy", busy, 0);
        chk("R1 strobes", strobes, 0);
        rd_status(s);
        chk("R1 R7 status", s, 8'h00);
    endtask

    task automatic t_no_latch();
        logic [7:0] s;
        prog_first(24'h10, 8'h55);
        chk("R2 no write without latch", strobes, 0);
        cmd(8'h06);
        rd_status(s);
        chk("R2 R7 latch set", s, 8'h02);
    endtask

    task automatic t_first();
        logic [7:0] s;
        prog_first(24'h000010, 8'h5A);
        chk("R3 strobe count", strobes, 1);
        chk("R3 address", last_a, 24'h10);
        chk("R3 data", last_d, 8'h5A);
        chk("R5 busy pin", busy, 1);
        rd_status(s);
        chk("R5 R7 status busy", s, 8'h03);
        wait_ready();
        rd_status(s);
        chk("R5 busy cleared", s, 8'h02);
    endtask

    task automatic t_next_and_busy();
        prog_next(8'h3C);
        chk("R4 next address", last_a, 24'h11);
        chk("R4 next data", last_d, 8'h3C);
        prog_next(8'h77);
        chk("R5 ignored while busy", strobes, 2);
        wait_ready();
    endtask

    task automatic t_stray();
        logic [7:0] s;
        cmd(8'h9F);
        cmd(8'h06);
        chk("R11 no write", strobes, 2);
        rd_status(s);
        chk("R11 status unchanged", s, 8'h02);
        prog_next(8'hC3);
        chk("R11 R4 pointer kept", last_a, 24'h12);
        wait_ready();
    endtask

    task automatic t_wrdi_and();
        logic [7:0] s;
        cmd(8'h04);
        rd_status(s);
        chk("R6 latch cleared", s, 8'h00);
        cmd(8'h06);
        prog_first(24'h000010, 8'h0F);
        chk("R6 address taken again", last_a, 24'h10);
        chk("R10 merged value", last_d, 8'h0A);
        wait_ready();
        cmd(8'h04);
    endtask

    task automatic t_protected();
        logic [7:0] s;
        cmd(8'h06);
        prog_first(24'h000100, 8'h00);
        chk("R9 no write", strobes, 4);
        rd_status(s);
        chk("R9 latch kept", s, 8'h02);
    endtask

    task automatic t_top();
        logic [7:0] s;
        prog_first(24'h0000FE, 8'hA5);
        chk("R8 FE write", last_a, 24'hFE);
        wait_ready();
        prog_next(8'h96);
        chk("R8 top address", last_a, 24'hFF);
        chk("R8 top data", last_d, 8'h96);
        wait_ready();
        rd_status(s);
        chk("R8 exit clears latch", s, 8'h00);
        cmd(8'h06);
        prog_next(8'h12);
        chk("R8 no wrap", strobes, 6);
    endtask

    initial begin
        ticks(5);
        rst_n = 1'b1;
        ticks(5);
        t_reset();
        t_no_latch();
        t_first();
        t_next_and_busy();
        t_stray();
        t_wrdi_and();
        t_protected();
        t_top();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 190000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule